// File: doc/BRIEF.md
# Sign-Magnitude Multiply-Accumulate Unit

This block is a sequential fixed-point arithmetic unit. Every value is held as a sign bit plus a magnitude, and never in two's complement. The unit keeps three registers:

- a double-length accumulator with a 64-bit magnitude;
- a multiplicand register with a 32-bit magnitude;
- a multiplier/quotient register.

Values are fractions with the binary point above the top bit. A one-word operand therefore lines up with the upper half of the accumulator, and a product of two words fills the whole accumulator.

A caller presents an operation code and a signed operand and pulses `start`. Single-cycle operations finish at the accepting edge. Multiply and divide raise `busy` for one step per clock over 32 steps. `done` pulses for one cycle when the result is visible.

Products and sums are added straight into the accumulator. The accumulator is never cleared or shifted by a multiply, so a chain of products and sums builds up at full double length with no rounding. Rounding to one word happens only on the separate rounded-result output, which is used when a value is taken out for storage or reused as a multiplicand.

Top module: `sm_mac_unit`

## Requirements
- R1: After reset the accumulator magnitude is 0, its sign is positive, and `overflow`, `busy` and `done` are all 0.
- R2: Operation codes are 0 clear, 1 add, 2 subtract, 3 load multiplicand, 4 multiply-add, 5 multiply-subtract, 6 halve, 7 divide.
  - Add and subtract combine the operand, placed in accumulator bits 63:32, with the accumulator in sign-magnitude form.
  - A sign bit of 1 means negative.
  - The accumulator changes only on an accepted start or while `busy` is high.
- R3: A carry out of accumulator bit 63 sets `overflow` and the magnitude wraps modulo 2^64.
  - `overflow` then stays 1 until a clear operation (code 0), which also zeroes the accumulator.
- R4: An accumulator magnitude of zero always carries a positive sign, including after a subtraction that cancels exactly.
- R5: Multiply-add adds, and multiply-subtract subtracts, the exact 64-bit product of the operand magnitude and the multiplicand magnitude.
  - The product's sign is the XOR of the two signs.
  - The accumulator is not cleared first.
- R6: Multiply-add, multiply-subtract and an accepted divide hold `busy` high for exactly 32 cycles, starting the cycle after the start.
  - `done` is 1 in the cycle after the last step and `busy` is then 0.
  - Any other operation gives `done` in the cycle after its start, and `busy` stays 0.
  - A start in the `done` cycle is accepted.
- R7: A completed multiply clears the multiplicand register, so a repeated multiply without a reload adds nothing.
- R8: Halve shifts the accumulator magnitude right by one bit and keeps its sign.
- R9: Divide is accepted when the operand magnitude D is nonzero and accumulator bits 63:32 are below D. It then:
  - puts floor(accumulator magnitude / D) into bits 63:32 and zeroes bits 31:0;
  - gives the result the sign XOR of the accumulator and operand signs;
  - clears the multiplicand register.
- R10: Otherwise divide leaves the accumulator unchanged, sets `overflow`, and completes like a single-cycle operation.
- R11: The rounded output is accumulator bits 63:32 plus bit 31, saturating at all ones.
  - It has the accumulator's sign, except that a rounded magnitude of zero is positive.
- R12: A start while `busy` is high is ignored.
- R13: Load multiplicand copies the operand sign and magnitude into the multiplicand register and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, sampled when not busy |
| opCode | input | 3 | Operation code |
| operandSign | input | 1 | Operand sign, 1 = negative |
| operandMag | input | 32 | Operand magnitude |
| busy | output | 1 | Multi-step operation in progress |
| done | output | 1 | Result visible this cycle |
| accSign | output | 1 | Accumulator sign |
| accMag | output | 64 | Accumulator magnitude |
| roundSign | output | 1 | Sign of the rounded one-word result |
| roundMag | output | 32 | Rounded one-word magnitude |
| overflow | output | 1 | Sticky carry-out flag |

## Verification
Two events can meet in one cycle: the `done` of a finishing multiply and the acceptance of the next start. The bench provokes this by issuing an add in the very cycle that `done` appears. It then checks that the accumulator holds both the product and the added operand.

A second collision is a start presented while a multiply is still stepping. The bench checks that this start leaves no trace in the final accumulator.

// File: rtl/sm_mac_pkg.sv
package sm_mac_pkg;

  typedef enum logic [2:0] {
    OP_CLR  = 3'd0,
    OP_ADD  = 3'd1,
    OP_SUB  = 3'd2,
    OP_LDM  = 3'd3,
    OP_MAC  = 3'd4,
    OP_MSUB = 3'd5,
    OP_HALF = 3'd6,
    OP_DIV  = 3'd7
  } op_e;

  // Strobes from control to datapath, at most one group active per cycle
  typedef struct packed {
    logic clr;
    logic addSub;
    logic negate;
    logic loadMd;
    logic half;
    logic mulInit;
    logic mulStep;
    logic divInit;
    logic divStep;
    logic divFail;
    logic lastStep;
  } strobes_t;

endpackage

// File: rtl/sm_mac_ctrl.sv
module sm_mac_ctrl
  import sm_mac_pkg::*;
#(
  parameter int MAG_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [2:0] opCode,
  input  logic       divOk,
  output strobes_t   strb,
  output logic       busy,
  output logic       done
);
  localparam int CNT_W = $clog2(MAG_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MAG_W - 1);

  logic             busyQ, isDivQ, doneQ;
  logic [CNT_W-1:0] cntQ;
  logic             accept, goLong;
  op_e              op;

  assign op     = op_e'(opCode);
  assign accept = start && !busyQ;
  assign goLong = (op == OP_MAC) || (op == OP_MSUB) || ((op == OP_DIV) && divOk);

  always_comb begin
    strb = '0;
    if (accept) begin
      case (op)
        OP_CLR:  strb.clr = 1'b1;
        OP_ADD:  strb.addSub = 1'b1;
        OP_SUB:  begin strb.addSub = 1'b1; strb.negate = 1'b1; end
        OP_LDM:  strb.loadMd = 1'b1;
        OP_MAC:  strb.mulInit = 1'b1;
        OP_MSUB: begin strb.mulInit = 1'b1; strb.negate = 1'b1; end
        OP_HALF: strb.half = 1'b1;
        OP_DIV:  begin strb.divInit = divOk; strb.divFail = !divOk; end
        default: ;
      endcase
    end
    if (busyQ) begin
      strb.mulStep  = !isDivQ;
      strb.divStep  = isDivQ;
      strb.lastStep = (cntQ == LAST);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      isDivQ <= 1'b0;
      doneQ  <= 1'b0;
      cntQ   <= '0;
    end else if (accept) begin
      busyQ  <= goLong;
      isDivQ <= (op == OP_DIV);
      doneQ  <= !goLong;
      cntQ   <= '0;
    end else if (busyQ) begin
      cntQ <= cntQ + 1'b1;
      if (cntQ == LAST) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else begin
        doneQ <= 1'b0;
      end
    end else begin
      doneQ <= 1'b0;
    end
  end

  assign busy = busyQ;
  assign done = doneQ;

endmodule

// File: rtl/sm_mac_dp.sv
module sm_mac_dp
  import sm_mac_pkg::*;
#(
  parameter int MAG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         strb,
  input  logic             operandSign,
  input  logic [MAG_W-1:0] operandMag,
  output logic             divOk,
  output logic             accSign,
  output logic [2*MAG_W-1:0] accMag,
  output logic             roundSign,
  output logic [MAG_W-1:0] roundMag,
  output logic             overflow
);
  localparam int ACC_W = 2 * MAG_W;
  localparam int REM_W = MAG_W + 2;

  logic             accSignQ, ovfQ, mdSignQ, effSignQ;
  logic [ACC_W-1:0] accMagQ, mdWorkQ;
  logic [MAG_W-1:0] mdMagQ, mrQ;
  logic [REM_W-1:0] remQ;

  // Sign-magnitude add: returns {carry, sign, magnitude}
  function automatic logic [ACC_W+1:0] smAdd(input logic aS, input logic [ACC_W-1:0] aM,
                                             input logic bS, input logic [ACC_W-1:0] bM);
    logic [ACC_W:0]   t;
    logic [ACC_W-1:0] m;
    logic             s, c;
    if (aS == bS) begin
      t = {1'b0, aM} + {1'b0, bM};
      m = t[ACC_W-1:0];
      s = aS;
      c = t[ACC_W];
    end else begin
      t = {1'b0, aM} - {1'b0, bM};
      c = 1'b0;
      if (t[ACC_W]) begin
        m = bM - aM;   // complement the negative difference, flip sign
        s = bS;
      end else begin
        m = t[ACC_W-1:0];
        s = aS;
      end
    end
    if (m == '0) s = 1'b0;
    return {c, s, m};
  endfunction

  logic             addSignIn;
  logic [ACC_W-1:0] addMagIn;
  logic [ACC_W+1:0] sumRes;
  logic [REM_W-1:0] shifted, divisorX, newRem;
  logic [MAG_W-1:0] quotient;
  logic [ACC_W-1:0] halved;

  always_comb begin
    if (strb.mulStep) begin
      addSignIn = effSignQ;
      addMagIn  = mrQ[MAG_W-1] ? mdWorkQ : '0;
    end else begin
      addSignIn = operandSign ^ strb.negate;
      addMagIn  = {operandMag, {MAG_W{1'b0}}};
    end
    sumRes   = smAdd(accSignQ, accMagQ, addSignIn, addMagIn);
    shifted  = {remQ[REM_W-2:0], accMagQ[MAG_W-1]};
    divisorX = {2'b00, mdMagQ};
    newRem   = remQ[REM_W-1] ? (shifted + divisorX) : (shifted - divisorX);
    quotient = {mrQ[MAG_W-2:0], ~newRem[REM_W-1]};
    halved   = accMagQ >> 1;
  end

  assign divOk = (operandMag != '0) && (accMagQ[ACC_W-1:MAG_W] < operandMag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accSignQ <= 1'b0;
      accMagQ  <= '0;
      ovfQ     <= 1'b0;
      mdSignQ  <= 1'b0;
      mdMagQ   <= '0;
      mdWorkQ  <= '0;
      mrQ      <= '0;
      remQ     <= '0;
      effSignQ <= 1'b0;
    end else begin
      if (strb.clr) begin
        accSignQ <= 1'b0;
        accMagQ  <= '0;
        ovfQ     <= 1'b0;
      end
      if (strb.addSub) begin
        accSignQ <= sumRes[ACC_W];
        accMagQ  <= sumRes[ACC_W-1:0];
        if (sumRes[ACC_W+1]) ovfQ <= 1'b1;
      end
      if (strb.loadMd) begin
        mdSignQ <= operandSign;
        mdMagQ  <= operandMag;
      end
      if (strb.half) begin
        accMagQ  <= halved;
        accSignQ <= accSignQ && (halved != '0);
      end
      if (strb.mulInit) begin
        mrQ      <= operandMag;
        mdWorkQ  <= {{MAG_W{1'b0}}, mdMagQ} << (MAG_W - 1);
        effSignQ <= mdSignQ ^ operandSign ^ strb.negate;
      end
      if (strb.mulStep) begin
        if (mrQ[MAG_W-1]) begin
          accSignQ <= sumRes[ACC_W];
          accMagQ  <= sumRes[ACC_W-1:0];
          if (sumRes[ACC_W+1]) ovfQ <= 1'b1;
        end
        mrQ     <= mrQ << 1;
        mdWorkQ <= mdWorkQ >> 1;
        if (strb.lastStep) begin
          mdMagQ  <= '0;
          mdSignQ <= 1'b0;
        end
      end
      if (strb.divInit) begin
        mdMagQ   <= operandMag;
        mdSignQ  <= operandSign;
        remQ     <= {2'b00, accMagQ[ACC_W-1:MAG_W]};
        effSignQ <= accSignQ ^ operandSign;
        mrQ      <= '0;
      end
      if (strb.divStep) begin
        remQ    <= newRem;
        mrQ     <= quotient;
        accMagQ <= accMagQ << 1;
        if (strb.lastStep) begin
          accMagQ  <= {quotient, {MAG_W{1'b0}}};
          accSignQ <= effSignQ && (quotient != '0);
          mdMagQ   <= '0;
          mdSignQ  <= 1'b0;
          remQ     <= '0;
        end
      end
      if (strb.divFail) ovfQ <= 1'b1;
    end
  end

  logic [MAG_W:0] roundSum;
  assign roundSum  = {1'b0, accMagQ[ACC_W-1:MAG_W]} + (MAG_W+1)'(accMagQ[MAG_W-1]);
  assign roundMag  = roundSum[MAG_W] ? {MAG_W{1'b1}} : roundSum[MAG_W-1:0];
  assign roundSign = accSignQ && (roundMag != '0);

  assign accSign  = accSignQ;
  assign accMag   = accMagQ;
  assign overflow = ovfQ;

endmodule

// File: rtl/sm_mac_unit.sv
module sm_mac_unit
  import sm_mac_pkg::*;
#(
  parameter int MAG_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [2:0]         opCode,
  input  logic               operandSign,
  input  logic [MAG_W-1:0]   operandMag,
  output logic               busy,
  output logic               done,
  output logic               accSign,
  output logic [2*MAG_W-1:0] accMag,
  output logic               roundSign,
  output logic [MAG_W-1:0]   roundMag,
  output logic               overflow
);
  strobes_t strb;
  logic     divOk;

  sm_mac_ctrl #(.MAG_W(MAG_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .divOk(divOk),
    .strb(strb), .busy(busy), .done(done)
  );

  sm_mac_dp #(.MAG_W(MAG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .operandSign(operandSign),
    .operandMag(operandMag), .divOk(divOk), .accSign(accSign), .accMag(accMag),
    .roundSign(roundSign), .roundMag(roundMag), .overflow(overflow)
  );

endmodule

// File: rtl/sm_mac_chk.sv
module sm_mac_chk #(
  parameter int MAG_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic [2:0]         opCode,
  input logic               busy,
  input logic               done,
  input logic               accSign,
  input logic [2*MAG_W-1:0] accMag,
  input logic               roundSign,
  input logic [MAG_W-1:0]   roundMag,
  input logic               overflow
);
  localparam int LEN_W = $clog2(MAG_W) + 2;
  logic [LEN_W-1:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else if (busy) busyLen <= busyLen + 1'b1;
    else busyLen <= '0;
  end

  p_zero_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accMag == '0) |-> !accSign);

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !(start && !busy && opCode == 3'd0)) |=> overflow);

  p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> ($stable(accMag) && $stable(accSign)));

  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  p_busy_len_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done && busyLen == LEN_W'(MAG_W)));

  p_round_zero_pos_r11: assert property (@(posedge clk) disable iff (!rstN)
    (roundMag == '0) |-> !roundSign);

endmodule

bind sm_mac_unit sm_mac_chk #(.MAG_W(MAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .busy(busy), .done(done),
  .accSign(accSign), .accMag(accMag), .roundSign(roundSign), .roundMag(roundMag),
  .overflow(overflow)
);

// File: tb/sm_mac_unit_tb_top.sv
module sm_mac_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAG_W = 32;
  localparam int NVEC = 26;

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        sgn;
    logic [31:0] mag;
    logic        eSign;
    logic [63:0] eMag;
    logic        eOvf;
  } vec_t;

  // op: 0 clr 1 add 2 sub 3 ldm 4 mac 5 msub 6 half 7 div
  localparam vec_t VECS [NVEC] = '{
    '{4'd3,  3'd0, 1'b0, 32'd0,          1'b0, 64'h0,                  1'b0}, // R3 clear
    '{4'd2,  3'd1, 1'b0, 32'd5,          1'b0, 64'h0000_0005_0000_0000, 1'b0}, // R2
    '{4'd2,  3'd2, 1'b0, 32'd8,          1'b1, 64'h0000_0003_0000_0000, 1'b0}, // R2 sign flip
    '{4'd4,  3'd1, 1'b0, 32'd3,          1'b0, 64'h0,                  1'b0}, // R4 zero positive
    '{4'd2,  3'd2, 1'b1, 32'd7,          1'b0, 64'h0000_0007_0000_0000, 1'b0}, // R2
    '{4'd13, 3'd3, 1'b0, 32'd3,          1'b0, 64'h0000_0007_0000_0000, 1'b0}, // R13
    '{4'd5,  3'd4, 1'b0, 32'd4,          1'b0, 64'h0000_0007_0000_000C, 1'b0}, // R5
    '{4'd7,  3'd4, 1'b0, 32'd4,          1'b0, 64'h0000_0007_0000_000C, 1'b0}, // R7
    '{4'd13, 3'd3, 1'b1, 32'h8000_0000,  1'b0, 64'h0000_0007_0000_000C, 1'b0}, // R13
    '{4'd5,  3'd4, 1'b0, 32'h4000_0000,  1'b1, 64'h1FFF_FFF8_FFFF_FFF4, 1'b0}, // R5
    '{4'd8,  3'd6, 1'b0, 32'd0,          1'b1, 64'h0FFF_FFFC_7FFF_FFFA, 1'b0}, // R8
    '{4'd3,  3'd0, 1'b0, 32'd0,          1'b0, 64'h0,                  1'b0}, // R3
    '{4'd2,  3'd1, 1'b0, 32'hFFFF_FFFF,  1'b0, 64'hFFFF_FFFF_0000_0000, 1'b0}, // R2
    '{4'd3,  3'd1, 1'b0, 32'd1,          1'b0, 64'h0,                  1'b1}, // R3 carry out
    '{4'd3,  3'd1, 1'b0, 32'd2,          1'b0, 64'h0000_0002_0000_0000, 1'b1}, // R3 sticky
    '{4'd3,  3'd0, 1'b0, 32'd0,          1'b0, 64'h0,                  1'b0}, // R3 clear
    '{4'd2,  3'd1, 1'b0, 32'd6,          1'b0, 64'h0000_0006_0000_0000, 1'b0}, // R2
    '{4'd13, 3'd3, 1'b1, 32'd5,          1'b0, 64'h0000_0006_0000_0000, 1'b0}, // R13
    '{4'd5,  3'd5, 1'b0, 32'd7,          1'b0, 64'h0000_0006_0000_0023, 1'b0}, // R5 msub
    '{4'd9,  3'd7, 1'b0, 32'd7,          1'b0, 64'hDB6D_B6E0_0000_0000, 1'b0}, // R9
    '{4'd10, 3'd7, 1'b0, 32'd1,          1'b0, 64'hDB6D_B6E0_0000_0000, 1'b1}, // R10
    '{4'd3,  3'd0, 1'b0, 32'd0,          1'b0, 64'h0,                  1'b0}, // R3
    '{4'd2,  3'd2, 1'b0, 32'd1,          1'b1, 64'h0000_0001_0000_0000, 1'b0}, // R2
    '{4'd9,  3'd7, 1'b1, 32'd3,          1'b0, 64'h5555_5555_0000_0000, 1'b0}, // R9 signs
    '{4'd10, 3'd7, 1'b0, 32'd0,          1'b0, 64'h5555_5555_0000_0000, 1'b1}, // R10 zero
    '{4'd9,  3'd4, 1'b0, 32'd5,          1'b0, 64'h5555_5555_0000_0000, 1'b1}  // R9 md cleared
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic        operandSign = 1'b0;
  logic [31:0] operandMag = '0;
  logic        busy, done, accSign, roundSign, overflow;
  logic [63:0] accMag;
  logic [31:0] roundMag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_mac_unit #(.MAG_W(MAG_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .opCode(opCode), .operandSign(operandSign),
    .operandMag(operandMag), .busy(busy), .done(done), .accSign(accSign), .accMag(accMag),
    .roundSign(roundSign), .roundMag(roundMag), .overflow(overflow)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Called just after a falling edge; returns at the falling edge where done is seen
  task automatic doOp(input logic [2:0] op, input logic s, input logic [31:0] m);
    opCode = op; operandSign = s; operandMag = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int busyCnt;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 accMag", accMag, 64'h0);
    check("R1 accSign", 64'(accSign), 64'h0);
    check("R1 overflow", 64'(overflow), 64'h0);
    check("R1 busy/done", 64'({busy, done}), 64'h0);

    for (int i = 0; i < NVEC; i++) begin
      doOp(VECS[i].op, VECS[i].sgn, VECS[i].mag);
      checks++;
      if (accMag !== VECS[i].eMag || accSign !== VECS[i].eSign || overflow !== VECS[i].eOvf) begin
        failures++;
        $display("FAIL R%0d vector %0d act=%b/%h/%b exp=%b/%h/%b", VECS[i].req, i,
                 accSign, accMag, overflow, VECS[i].eSign, VECS[i].eMag, VECS[i].eOvf);
      end
    end

    // R11 rounding up
    doOp(3'd0, 1'b0, 32'd0);
    doOp(3'd1, 1'b0, 32'd1);
    doOp(3'd3, 1'b0, 32'd1);
    doOp(3'd4, 1'b0, 32'h8000_0000);
    check("R11 round up mag", 64'(roundMag), 64'd2);
    check("R11 round up sign", 64'(roundSign), 64'd0);
    // R11 negative value rounding to zero is positive
    doOp(3'd0, 1'b0, 32'd0);
    doOp(3'd3, 1'b1, 32'd1);
    doOp(3'd4, 1'b0, 32'h4000_0000);
    check("R11 small neg acc", {accSign, accMag[62:0]}, {1'b1, 63'h4000_0000});
    check("R11 round to zero", 64'({roundSign, roundMag}), 64'd0);
    // R11 saturation
    doOp(3'd0, 1'b0, 32'd0);
    doOp(3'd1, 1'b0, 32'hFFFF_FFFF);
    doOp(3'd3, 1'b0, 32'd1);
    doOp(3'd4, 1'b0, 32'h8000_0000);
    check("R11 saturate", 64'(roundMag), 64'hFFFF_FFFF);

    // R6 busy length, then a start in the done cycle
    doOp(3'd0, 1'b0, 32'd0);
    doOp(3'd3, 1'b0, 32'd3);
    opCode = 3'd4; operandSign = 1'b0; operandMag = 32'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyCnt = 0;
    while (busy && busyCnt < 100) begin
      busyCnt++;
      @(negedge clk);
    end
    check("R6 busy cycles", 64'(busyCnt), 64'd32);
    check("R6 done after last step", 64'(done), 64'd1);
    check("R5 product 3*5", accMag, 64'd15);
    opCode = 3'd1; operandSign = 1'b0; operandMag = 32'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 single op done, not busy", 64'({busy, done}), 64'd1);
    check("R6 back-to-back add", accMag, 64'h0000_0001_0000_000F);

    // R12 start during busy ignored
    doOp(3'd3, 1'b0, 32'd2);
    opCode = 3'd4; operandSign = 1'b0; operandMag = 32'd3; start = 1'b1;
    @(negedge clk);
    opCode = 3'd1; operandMag = 32'h100;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R12 ignored start", accMag, 64'h0000_0001_0000_0015);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule